// File: doc/BRIEF.md
# Gated Period Timer

A 16-bit up-counter that runs against a programmable period and raises a sticky status flag. Every count step comes from a selectable source: either a one-cycle internal tick supplied by the surrounding chip, or the rising edges of an external pin after they have been synchronized into the system clock. A 2-bit field selects a prescale divider of 1, 8, 64 or 256, which thins that source before it reaches the counter.

In gated mode the internal tick is counted only while the synchronized pin is high. The flag then marks the end of each high pulse rather than a period match, so software can measure the width of a pulse. All configuration, the count, the period and the flag are reached through a small register port. Writes to that port can target one byte or the full word. Reads return data one cycle later and must cover the full word.

Register addresses are 0 for control, 1 for count, 2 for period and 3 for status. Byte enable bit 0 selects bits 7:0 and bit 1 selects bits 15:8.

Top module: `gated_period_timer`

## Requirements
- R1: After a synchronous reset, the control, count and period registers read as zero and the flag output is low.
- R2: Control bits 5:4 set the prescale ratio. 00 divides by 1, 01 by 8, 10 by 64 and 11 by 256, so the count advances once per that many source events.
- R3: When the count equals a nonzero period, the next count step loads zero and sets the flag, so the count sequence is P-1, P, 0, 1.
- R4: The prescaler phase is cleared by any write to the count register and while the run bit is low. After either event, a full ratio of source events is needed for the next step.
- R5: While the period register is zero, a count step never sets the flag.
- R6: When control bit 2 (gate) is set and bit 1 is clear, internal ticks are counted only while the synchronized pin is high. A high-to-low pin transition sets the flag, and a period match does not set it.
- R7: In a cycle that writes the count register, the hardware increment of that cycle is dropped and the written value is kept.
- R8: A byte write to the count changes only the selected half. A carry out of the low half still advances the high half on the next step.
- R9: A read with both byte enables returns the addressed register on the next cycle. A read with any other byte enable pattern returns zero.
- R10: At address 3, bit 0 is the flag. Writing 0 to it clears the flag, writing 1 has no effect, and a hardware set in the same cycle as a clear leaves the flag set.
- R11: When control bit 1 (external) is set, the counter steps on synchronized rising edges of the pin. In that mode the internal tick and the gate bit are ignored, and pin falling edges do not set the flag.
- R12: While control bit 0 (run) is low, the count does not change except by register writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Internal instruction-cycle tick, one cycle wide |
| ext_pin | input | 1 | Asynchronous external clock or gate pin |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| be | input | 2 | Byte enables, bit 0 for the low byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid the cycle after rd_en |
| flag_o | output | 1 | Sticky status flag |

## Verification
The properties assume the register port is driven with one operation per cycle and that the external pin stays at each level for at least three system clocks, so the synchronizer cannot miss an edge. The stimulus respects both limits. It holds the pin steady for three or more cycles around every transition, and it keeps the internal tick low during configuration writes, except where the tick is raised on purpose to collide with a count write or a flag clear. Because tick pulses are applied in exact numbers, every expected count follows directly from the prescale ratio and the period.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_COUNT  = 2'd1,
    RA_PERIOD = 2'd2,
    RA_STATUS = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] ps;
    logic       gate;
    logic       ext;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/gpt_pin_sync.sv
module gpt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[LAST-1:0], pin};
  end

  assign level = sh[LAST-1];
  assign rise  = sh[LAST-1] & ~sh[LAST];
  assign fall  = ~sh[LAST-1] & sh[LAST];
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PS_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       src,
  input  logic [1:0] sel,
  output logic       pulse
);
  logic [PS_W-1:0] phase;
  logic [PS_W-1:0] lim;

  always_comb begin
    case (sel)
      2'b00:   lim = PS_W'(0);
      2'b01:   lim = PS_W'((1 << 3) - 1);
      2'b10:   lim = PS_W'((1 << 6) - 1);
      default: lim = PS_W'((1 << 8) - 1);
    endcase
  end

  assign pulse = src && (phase == lim);

  always_ff @(posedge clk) begin
    if (rst || clr)  phase <= '0;
    else if (src)    phase <= pulse ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         match
);
  localparam int HB = W / 2;

  logic wr_any;
  logic at_end;

  assign wr_any = wr_lo | wr_hi;
  assign at_end = (count == period);
  assign match  = inc && !wr_any && at_end && (period != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (wr_any) begin
      if (wr_lo) count[HB-1:0] <= wdata[HB-1:0];
      if (wr_hi) count[W-1:HB] <= wdata[W-1:HB];
    end else if (inc) begin
      count <= at_end ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
  import gpt_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              ext_pin,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [1:0]        be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              flag_o
);
  localparam int HB = DATA_W / 2;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] prd_q;
  logic [DATA_W-1:0] cnt_q;
  logic              flag_q;
  logic [DATA_W-1:0] rd_mux;

  logic pin_lvl, pin_rise, pin_fall;
  logic run_en, gate_mode;
  logic src_tick, ps_pulse, match;
  logic cnt_wr_lo, cnt_wr_hi;
  logic sel_ctrl, sel_cnt, sel_prd, sel_stat;
  logic flag_set, flag_clr;

  assign sel_ctrl = wr_en && (addr == RA_CTRL);
  assign sel_cnt  = wr_en && (addr == RA_COUNT);
  assign sel_prd  = wr_en && (addr == RA_PERIOD);
  assign sel_stat = wr_en && (addr == RA_STATUS);

  assign cnt_wr_lo = sel_cnt && be[0];
  assign cnt_wr_hi = sel_cnt && be[1];

  assign run_en    = ctrl_q.run;
  assign gate_mode = ctrl_q.gate && !ctrl_q.ext;

  gpt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin   (ext_pin),
    .level (pin_lvl),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  always_comb begin
    if (ctrl_q.ext)     src_tick = pin_rise;
    else if (gate_mode) src_tick = tick_in && pin_lvl;
    else                src_tick = tick_in;
  end

  gpt_prescaler #(.PS_W(PS_W)) u_ps (
    .clk   (clk),
    .rst   (rst),
    .clr   (!run_en || cnt_wr_lo || cnt_wr_hi),
    .src   (src_tick),
    .sel   (ctrl_q.ps),
    .pulse (ps_pulse)
  );

  gpt_count_core #(.W(DATA_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .inc    (ps_pulse && run_en),
    .wr_lo  (cnt_wr_lo),
    .wr_hi  (cnt_wr_hi),
    .wdata  (wdata),
    .period (prd_q),
    .count  (cnt_q),
    .match  (match)
  );

  // control and period registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      prd_q  <= '0;
    end else begin
      if (sel_ctrl && be[0]) begin
        ctrl_q.run  <= wdata[0];
        ctrl_q.ext  <= wdata[1];
        ctrl_q.gate <= wdata[2];
        ctrl_q.ps   <= wdata[5:4];
      end
      if (sel_prd && be[0]) prd_q[HB-1:0]      <= wdata[HB-1:0];
      if (sel_prd && be[1]) prd_q[DATA_W-1:HB] <= wdata[DATA_W-1:HB];
    end
  end

  // sticky flag: a hardware set beats a software clear
  assign flag_set = run_en && (gate_mode ? pin_fall : match);
  assign flag_clr = sel_stat && be[0] && !wdata[0];

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (flag_set) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  always_comb begin
    rd_mux = '0;
    case (addr)
      RA_CTRL: begin
        rd_mux[0]   = ctrl_q.run;
        rd_mux[1]   = ctrl_q.ext;
        rd_mux[2]   = ctrl_q.gate;
        rd_mux[5:4] = ctrl_q.ps;
      end
      RA_COUNT:  rd_mux = cnt_q;
      RA_PERIOD: rd_mux = prd_q;
      default:   rd_mux[0] = flag_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_en)  rdata <= (be == 2'b11) ? rd_mux : '0;
  end
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         rd_en,
  input logic [1:0]   addr,
  input logic [1:0]   be,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic         flag_o,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] prd_q,
  input logic         run_en,
  input logic         gate_mode
);
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !(wr_en && addr == 2'd3 && be[0] && !wdata[0])) |=> flag_o);

  // R5
  zero_period_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && prd_q == '0 && !gate_mode) |=> !flag_o);

  // R7
  count_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1 && be == 2'b11) |=> (cnt_q == $past(wdata)));

  // R8
  low_byte_keeps_high_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1 && be == 2'b01) |=> (cnt_q[W-1:W/2] == $past(cnt_q[W-1:W/2])));

  // R9
  byte_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && be != 2'b11) |=> (rdata == '0));

  // R12
  halted_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !(wr_en && addr == 2'd1)) |=> $stable(cnt_q));
endmodule

bind gated_period_timer gpt_timer_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .be        (be),
  .wdata     (wdata),
  .rdata     (rdata),
  .flag_o    (flag_o),
  .cnt_q     (cnt_q),
  .prd_q     (prd_q),
  .run_en    (run_en),
  .gate_mode (gate_mode)
);

// File: tb/gated_period_timer_tb.sv
module gated_period_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_in = 1'b0;
  logic        ext_pin = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [1:0]  be = 2'b11;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        flag_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  logic rd_seen = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  gated_period_timer u_dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .ext_pin(ext_pin),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .flag_o(flag_o)
  );

  // monitor: compares read results against the scoreboard
  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen && sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      n_chk++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [1:0] b,
                        input logic [15:0] d, input logic tk);
    @(negedge clk);
    wr_en = 1'b1; addr = a; be = b; wdata = d; tick_in = tk;
    @(negedge clk);
    wr_en = 1'b0; tick_in = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [1:0] b,
                        input logic [15:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    rd_en = 1'b1; addr = a; be = b;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_in = 1'b1;
    end
    @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_flag(input logic e, input string tag);
    @(negedge clk);
    n_chk++;
    if (flag_o !== e) begin
      n_fail++;
      $display("FAIL %s: flag_o=%b expected=%b", tag, flag_o, e);
    end
  endtask

  task automatic pin_pulse(input int hi, input int lo);
    @(negedge clk); ext_pin = 1'b1;
    idle(hi);
    @(negedge clk); ext_pin = 1'b0;
    idle(lo);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk_flag(1'b0, "R1 flag after reset");
    bus_rd(2'd0, 2'b11, 16'h0000, "R1 control after reset");
    bus_rd(2'd1, 2'b11, 16'h0000, "R1 count after reset");
    bus_rd(2'd2, 2'b11, 16'h0000, "R1 period after reset");

    // R9 control readback
    bus_wr(2'd0, 2'b11, 16'h0035, 1'b0);
    bus_rd(2'd0, 2'b11, 16'h0035, "R9 control readback");

    // R3 period match, prescale 1:1
    bus_wr(2'd0, 2'b11, 16'h0001, 1'b0);
    bus_wr(2'd2, 2'b11, 16'd5, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd0, 1'b0);
    ticks(5);
    bus_rd(2'd1, 2'b11, 16'd5, "R3 count reaches period");
    chk_flag(1'b0, "R3 no flag before wrap");
    ticks(1);
    bus_rd(2'd1, 2'b11, 16'd0, "R3 count wraps to zero");
    chk_flag(1'b1, "R3 flag on match");

    // R10 flag write rules
    bus_wr(2'd3, 2'b11, 16'h0001, 1'b0);
    chk_flag(1'b1, "R10 write one ignored");
    bus_rd(2'd3, 2'b11, 16'h0001, "R10 status reads flag");
    bus_wr(2'd3, 2'b11, 16'h0000, 1'b0);
    chk_flag(1'b0, "R10 write zero clears");
    bus_wr(2'd2, 2'b11, 16'd1, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd0, 1'b0);
    ticks(1);
    bus_wr(2'd3, 2'b11, 16'h0000, 1'b1);
    chk_flag(1'b1, "R10 set beats clear");
    bus_rd(2'd1, 2'b11, 16'd0, "R10 count wrapped on collision");
    bus_wr(2'd3, 2'b11, 16'h0000, 1'b0);

    // R2 prescale ratios
    bus_wr(2'd2, 2'b11, 16'hFFFF, 1'b0);
    bus_wr(2'd0, 2'b11, 16'h0011, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd0, 1'b0);
    ticks(7);
    bus_rd(2'd1, 2'b11, 16'd0, "R2 1:8 before boundary");
    ticks(1);
    bus_rd(2'd1, 2'b11, 16'd1, "R2 1:8 first step");
    ticks(16);
    bus_rd(2'd1, 2'b11, 16'd3, "R2 1:8 three steps");
    bus_wr(2'd0, 2'b11, 16'h0021, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd0, 1'b0);
    ticks(192);
    bus_rd(2'd1, 2'b11, 16'd3, "R2 1:64 three steps");
    bus_wr(2'd0, 2'b11, 16'h0031, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd0, 1'b0);
    ticks(767);
    bus_rd(2'd1, 2'b11, 16'd2, "R2 1:256 two steps");

    // R4 prescaler clears
    bus_wr(2'd0, 2'b11, 16'h0011, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd0, 1'b0);
    ticks(5);
    bus_wr(2'd1, 2'b11, 16'd10, 1'b0);
    ticks(7);
    bus_rd(2'd1, 2'b11, 16'd10, "R4 count write clears phase");
    ticks(1);
    bus_rd(2'd1, 2'b11, 16'd11, "R4 step after full ratio");
    ticks(5);
    bus_wr(2'd0, 2'b11, 16'h0010, 1'b0);
    bus_wr(2'd0, 2'b11, 16'h0011, 1'b0);
    ticks(7);
    bus_rd(2'd1, 2'b11, 16'd11, "R4 run clear resets phase");
    ticks(1);
    bus_rd(2'd1, 2'b11, 16'd12, "R4 step after restart");

    // R12 halted
    bus_wr(2'd0, 2'b11, 16'h0000, 1'b0);
    ticks(10);
    bus_rd(2'd1, 2'b11, 16'd12, "R12 halted count holds");

    // R5 zero period
    bus_wr(2'd0, 2'b11, 16'h0001, 1'b0);
    bus_wr(2'd2, 2'b11, 16'd0, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd0, 1'b0);
    ticks(20);
    chk_flag(1'b0, "R5 zero period no flag");
    bus_rd(2'd1, 2'b11, 16'd0, "R5 count stays zero");

    // R7 write suppresses increment
    bus_wr(2'd2, 2'b11, 16'hFFFF, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd100, 1'b1);
    bus_rd(2'd1, 2'b11, 16'd100, "R7 increment dropped on write");

    // R8 byte writes and carry
    bus_wr(2'd1, 2'b11, 16'h12FF, 1'b0);
    bus_wr(2'd1, 2'b01, 16'h00AB, 1'b0);
    bus_rd(2'd1, 2'b11, 16'h12AB, "R8 low byte write");
    bus_wr(2'd1, 2'b10, 16'h3400, 1'b0);
    bus_rd(2'd1, 2'b11, 16'h34AB, "R8 high byte write");
    bus_wr(2'd1, 2'b01, 16'h00FF, 1'b0);
    ticks(1);
    bus_rd(2'd1, 2'b11, 16'h3500, "R8 carry into high byte");

    // R9 byte reads
    bus_rd(2'd1, 2'b01, 16'h0000, "R9 low byte read zero");
    bus_rd(2'd1, 2'b10, 16'h0000, "R9 high byte read zero");

    // R6 gated accumulation
    bus_wr(2'd0, 2'b11, 16'h0005, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd0, 1'b0);
    @(negedge clk) ext_pin = 1'b1;
    idle(4);
    ticks(10);
    bus_rd(2'd1, 2'b11, 16'd10, "R6 counts while gate high");
    chk_flag(1'b0, "R6 no flag while high");
    @(negedge clk) ext_pin = 1'b0;
    idle(4);
    chk_flag(1'b1, "R6 falling gate sets flag");
    ticks(5);
    bus_rd(2'd1, 2'b11, 16'd10, "R6 no count while gate low");
    bus_wr(2'd3, 2'b11, 16'h0000, 1'b0);
    bus_wr(2'd2, 2'b11, 16'd2, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd0, 1'b0);
    @(negedge clk) ext_pin = 1'b1;
    idle(4);
    ticks(6);
    bus_rd(2'd1, 2'b11, 16'd0, "R6 wraps in gated mode");
    chk_flag(1'b0, "R6 match sets no flag");
    @(negedge clk) ext_pin = 1'b0;
    idle(4);
    bus_wr(2'd3, 2'b11, 16'h0000, 1'b0);

    // R11 external source, gate bit ignored
    bus_wr(2'd0, 2'b11, 16'h0007, 1'b0);
    bus_wr(2'd2, 2'b11, 16'hFFFF, 1'b0);
    bus_wr(2'd1, 2'b11, 16'd0, 1'b0);
    for (int k = 0; k < 4; k++) pin_pulse(3, 3);
    idle(3);
    bus_rd(2'd1, 2'b11, 16'd4, "R11 counts pin rising edges");
    chk_flag(1'b0, "R11 pin fall sets no flag");
    ticks(10);
    bus_rd(2'd1, 2'b11, 16'd4, "R11 internal tick ignored");

    idle(4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule